// File: doc/BRIEF.md
# Three-Stage Negotiation Clock Divider

This block derives a slow timing-negotiation strobe for a single-wire sideband bus from a fast reference clock. It does not toggle a clock. It raises a one-cycle enable, `tick_o`, once per division period. The period in reference cycles is the product of three cascaded counters:

- a fixed divide-by-4 prescaler;
- a linear stage that counts 4·m + 1 prescaler wraps, where m is the 8-bit message-timing value;
- a power-of-two stage that counts 2^e linear-stage wraps, where e is the 3-bit exponent.

The whole period is therefore 4·(4·m + 1)·2^e reference cycles.

The block also receives a second timing value, the address-timing value. Software normally writes it equal to the message value. The configuration counts as usable only when both values are equal and nonzero. `cfg_valid_o` reports this as a combinational function of the live inputs. While the configuration is unusable or `enable_i` is low, every counter is held at zero and no tick is produced.

The block captures m and e at each period boundary. A new setting therefore never shortens or stretches a period that is already in progress.

Top module: `nego_clk_div`

## Requirements
- R1: While running with a fixed configuration, consecutive ticks are exactly 4·(4·m + 1)·2^e reference cycles apart.
- R2: `tick_o` is high for exactly one reference cycle per period.
- R3: After `enable_i` rises with a valid configuration, the first tick is seen N cycles later, where N is the period of R1. `tick_o` is a registered output.
- R4: While `enable_i` is low, no tick is issued. Re-enabling restarts a full period from zero.
- R5: `cfg_valid_o` is 1 exactly when the message value equals the address value and the message value is nonzero. It follows the inputs combinationally, including during reset.
- R6: When the message and address values differ, no tick is issued and the counters clear. Once they agree again, a full new period elapses before the next tick.
- R7: A message value of 0 issues no ticks.
- R8: A change to m or e in mid-period takes effect only at the next period boundary. The current period completes with the old ratio.
- R9: The whole exponent range 0 to 7 is honoured, so e = 7 multiplies the period by 128.
- R10: During reset, `tick_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run request; low holds all stages at zero |
| msg_timing_i | input | 8 | Linear-stage value m (valid 1..255) |
| addr_timing_i | input | 8 | Address-timing value; must equal m |
| div_exp_i | input | 3 | Power-of-two exponent e |
| tick_o | output | 1 | One-cycle strobe at the divided rate |
| cfg_valid_o | output | 1 | Configuration is usable |

## Verification
A period boundary and a configuration write can fall in the same cycle. A write of new m or e can also land just before a boundary. The bench writes new values partway through a running period. It then measures the closing period against the old ratio and the next period against the new ratio.

A disabling event can also coincide with counting. The bench drops `enable_i`, or makes the two timing values disagree, while the counters are mid-period. It then requires silence, followed by a full-length first period after the block is restored.

// File: rtl/nego_clk_div_pkg.sv
package nego_clk_div_pkg;
  // Fixed first-stage ratio is 4: a two-bit counter wrapping at 3.
  localparam int PRE_W   = 2;
  localparam int PRE_LIM = 3;
endpackage

// File: rtl/nego_div_stage.sv
module nego_div_stage #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         step_i,
  input  logic [W-1:0] lim_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_lim;

  assign at_lim = (cnt_q == lim_i);
  assign wrap_o = run_i & step_i & at_lim;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (step_i) begin
      cnt_d = at_lim ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

  // R1
  within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= lim_i));
endmodule

// File: rtl/nego_cfg_hold.sv
module nego_cfg_hold #(
  parameter int MSG_W = 8,
  parameter int EXP_W = 3,
  parameter int LIN_W = MSG_W + 2,
  parameter int POW_W = (1 << EXP_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic [MSG_W-1:0] msg_i,
  input  logic [MSG_W-1:0] addr_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             period_end_i,
  output logic             run_o,
  output logic             cfg_valid_o,
  output logic [LIN_W-1:0] lin_lim_o,
  output logic [POW_W-1:0] pow_lim_o
);
  logic             started_q;
  logic             started_d;
  logic [MSG_W-1:0] m_q;
  logic [MSG_W-1:0] m_d;
  logic [EXP_W-1:0] e_q;
  logic [EXP_W-1:0] e_d;
  logic [MSG_W-1:0] m_act;
  logic [EXP_W-1:0] e_act;
  logic             load;

  assign cfg_valid_o = (msg_i == addr_i) && (msg_i != '0);
  assign run_o       = enable_i & cfg_valid_o;

  // The first running cycle uses the live value; afterwards the captured one.
  assign m_act = started_q ? m_q : msg_i;
  assign e_act = started_q ? e_q : exp_i;
  assign load  = !started_q || period_end_i;

  always_comb begin
    started_d = run_o;
    m_d       = load ? msg_i : m_q;
    e_d       = load ? exp_i : e_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      m_q       <= '0;
      e_q       <= '0;
    end else begin
      started_q <= started_d;
      m_q       <= m_d;
      e_q       <= e_d;
    end
  end

  assign lin_lim_o = {m_act, 2'b00};

  always_comb begin
    for (int i = 0; i < POW_W; i++) begin
      pow_lim_o[i] = (i < int'(e_act));
    end
  end

  // R8
  cfg_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && run_o && !period_end_i) |=> ($stable(m_q) && $stable(e_q)));
endmodule

// File: rtl/nego_clk_div.sv
module nego_clk_div #(
  parameter int MSG_W = 8,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic [MSG_W-1:0] msg_timing_i,
  input  logic [MSG_W-1:0] addr_timing_i,
  input  logic [EXP_W-1:0] div_exp_i,
  output logic             tick_o,
  output logic             cfg_valid_o
);
  import nego_clk_div_pkg::*;

  localparam int LIN_W = MSG_W + 2;
  localparam int POW_W = (1 << EXP_W) - 1;

  logic             run;
  logic [LIN_W-1:0] lin_lim;
  logic [POW_W-1:0] pow_lim;
  logic             pre_wrap;
  logic             lin_wrap;
  logic             pow_wrap;
  logic             tick_q;
  logic             tick_d;

  nego_cfg_hold #(
    .MSG_W(MSG_W), .EXP_W(EXP_W), .LIN_W(LIN_W), .POW_W(POW_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
    .msg_i(msg_timing_i), .addr_i(addr_timing_i), .exp_i(div_exp_i),
    .period_end_i(pow_wrap), .run_o(run), .cfg_valid_o(cfg_valid_o),
    .lin_lim_o(lin_lim), .pow_lim_o(pow_lim)
  );

  nego_div_stage #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(1'b1),
    .lim_i(PRE_W'(PRE_LIM)), .wrap_o(pre_wrap)
  );

  nego_div_stage #(.W(LIN_W)) u_lin (
    .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(pre_wrap),
    .lim_i(lin_lim), .wrap_o(lin_wrap)
  );

  nego_div_stage #(.W(POW_W)) u_pow (
    .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(lin_wrap),
    .lim_i(pow_lim), .wrap_o(pow_wrap)
  );

  assign tick_d = pow_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_d;
  end

  assign tick_o = tick_q;

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  // R6
  invalid_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid_o |=> !tick_o);

  // R4
  tick_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(enable_i));
endmodule

// File: tb/nego_clk_div_tb.sv
module nego_clk_div_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [7:0] msg;
  logic [7:0] addr;
  logic [2:0] dexp;
  logic       tick;
  logic       cfg_valid;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nego_clk_div u_dut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable),
    .msg_timing_i(msg), .addr_timing_i(addr), .div_exp_i(dexp),
    .tick_o(tick), .cfg_valid_o(cfg_valid)
  );

  function automatic int exp_period(int m, int e);
    return 4 * (4 * m + 1) * (1 << e);
  endfunction

  function automatic bit exp_valid(int m, int a);
    return (m == a) && (m != 0);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      check(1'b0, "watchdog", cyc, WATCHDOG);
      finish_run();
    end
  end

  // Counts negedges until tick is seen (or limit reached).
  task automatic to_tick(int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < limit);
  endtask

  // Called at the negedge where tick is high: checks width and next gap.
  task automatic next_period(int limit, output int n);
    @(negedge clk);
    check(!tick, "R2 tick width", tick, 0);
    n = 1;
    while (!tick && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic quiet(int cycles, string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  task automatic run_case(int m, int e, string req);
    int n;
    int nexp = exp_period(m, e);
    msg = 8'(m); addr = 8'(m); dexp = 3'(e); enable = 1'b1;
    to_tick(nexp + 8, n);
    check(n == nexp, {req, " R3 first tick"}, n, nexp);
    next_period(nexp + 8, n);
    check(n == nexp, {req, " R1 period"}, n, nexp);
    enable = 1'b0;
    quiet(40, "R4 disabled silent");
  endtask

  initial begin
    int n;
    int m;
    int e;
    void'($urandom(32'd1234));
    rst_n = 1'b0; enable = 1'b0; msg = 8'd5; addr = 8'd5; dexp = 3'd0;
    @(negedge clk);
    check(tick == 1'b0, "R10 reset tick", tick, 0);
    check(cfg_valid == 1'b1, "R5 valid in reset", cfg_valid, 1);
    enable = 1'b1;
    quiet(5, "R10 no tick in reset");
    enable = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    run_case(1, 0, "R1 min");
    run_case(1, 7, "R9 e=7");
    run_case(255, 0, "R1 m=255");
    run_case(2, 3, "R9 e=3");
    for (int k = 0; k < 12; k++) begin
      m = 1 + int'($urandom_range(19));
      e = int'($urandom_range(3));
      run_case(m, e, "R1 random");
    end

    // R8: change in mid-period
    msg = 8'd3; addr = 8'd3; dexp = 3'd1; enable = 1'b1;
    to_tick(exp_period(3, 1) + 8, n);
    check(n == exp_period(3, 1), "R8 first", n, exp_period(3, 1));
    @(negedge clk);
    n = 1;
    for (int i = 0; i < 29; i++) begin @(negedge clk); n++; end
    msg = 8'd2; addr = 8'd2; dexp = 3'd2;
    while (!tick && n < 400) begin @(negedge clk); n++; end
    check(n == exp_period(3, 1), "R8 old ratio kept", n, exp_period(3, 1));
    next_period(400, n);
    check(n == exp_period(2, 2), "R8 new ratio", n, exp_period(2, 2));

    // R6: mismatch stops and clears
    for (int i = 0; i < 7; i++) @(negedge clk);
    addr = 8'd9;
    #1;
    check(cfg_valid == exp_valid(2, 9), "R5 mismatch flag", cfg_valid, 0);
    quiet(300, "R6 mismatch silent");
    addr = 8'd2;
    #1;
    check(cfg_valid == 1'b1, "R5 agree flag", cfg_valid, 1);
    to_tick(400, n);
    check(n == exp_period(2, 2), "R6 full period after agree", n, exp_period(2, 2));

    // R7: zero message value
    msg = 8'd0; addr = 8'd0;
    #1;
    check(cfg_valid == 1'b0, "R7 zero invalid", cfg_valid, 0);
    quiet(200, "R7 zero silent");

    // R4: short disable in mid-period restarts from zero
    msg = 8'd2; addr = 8'd2; dexp = 3'd0;
    for (int i = 0; i < 10; i++) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    to_tick(100, n);
    check(n == exp_period(2, 0), "R4 restart latency", n, exp_period(2, 0));
    enable = 1'b0;
    quiet(50, "R4 disabled silent");

    finish_run();
  end
endmodule